// File: doc/BRIEF.md
# Cartridge ROM Block Read Controller

This controller sits on the host side of a cartridge slot. Software first writes the command bytes into a staging bank. It then writes a control word with the go bit set. The controller decodes the staged opcode when the go write is accepted. A streaming-read opcode takes a 32-bit start address from the staged bytes. It then fetches a programmed number of bytes, one 32-bit word at a time, from a synchronous ROM read port. A chip-identity opcode puts a fixed identity word in the read buffer. Any other opcode is rejected and raises an error flag.

The host pops words through a valid/ready pair. `rd_valid` is high while a word is waiting. `rd_data` and `rd_valid` stay stable until the host raises `rd_ready`. A word moves on the rising edge where both are high. `rd_ready` has no effect while `rd_valid` is low. The controller never fetches ahead. After each pop it waits a pacing delay and only then fetches the next word. When it finds the byte count at zero, it closes the transfer and can raise an interrupt.

The pacing delay is 5 cycles in fast mode and 8 cycles in slow mode. The delay doubles when the secondary bus owner is not selected. The owner input is sampled whenever a delay is scheduled. A DMA request pulse goes with every word fetched from the ROM, if DMA is armed.

Top module: `crx_rom_reader`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `irq`, `dma_req`, `err` and `rom_en` are all 0.
- R2: A control write with `ctl_go` = 1 starts a transfer only while `busy` is 0. A go write made while busy does not change the running transfer's words, timing or `err`. Staging-byte writes made while busy take effect only at the next accepted start.
- R3: Opcode 0xB7, held in staging byte 0, streams words from the ROM. The start address is formed from staging bytes 1, 2, 3 and 4, with byte 1 as the most significant. Word k is the ROM word at start + 4k.
- R4: The 3-bit size code n gives the length in bytes. Code 0 gives 0 bytes, code 7 gives 4 bytes, and codes 1 to 6 give 256 << n bytes. The number of ROM reads is the length divided by 4.
- R5: Let L be 5 when `ctl_slow` = 0 and 8 when `ctl_slow` = 1, doubled when `owner_sec` = 0. `rd_valid` rises L+2 cycles after the edge that accepts a streaming start, or after the edge that pops a word.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` is stable and `rom_en` stays low.
- R7: The transfer closes L cycles after the start edge or the last pop. If the length is still nonzero then, the next word is fetched instead. On close, `busy` falls, `rd_data` becomes 0, and `irq` pulses for one cycle only if `ctl_irq_en` was set at start.
- R8: Opcode 0xB8 makes `rd_valid` high with `rd_data` equal to the CHIP_ID parameter in the cycle after the start edge. The transfer closes L cycles after that word is popped.
- R9: Any other opcode keeps `busy` high for exactly one cycle. It sets `err`, leaves `rd_data` unchanged, and gives no `rd_valid` and no `irq`. `err` stays set until the next accepted start clears it.
- R10: `dma_req` pulses for one cycle, together with the rising `rd_valid`, for each word fetched from the ROM, if `dma_arm` is 1. It never pulses otherwise.
- R11: Each fetched word produces exactly one single-cycle `rom_en` pulse, with `rom_addr` equal to that word's address. `rom_addr` holds until the data is captured one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Staging byte write strobe |
| cmd_idx | input | 3 | Staging byte index (0 opcode, 1..4 address MSB first, 5..7 accepted but unused) |
| cmd_byte | input | 8 | Staging byte value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_size | input | 3 | Block size code |
| ctl_slow | input | 1 | Slow pacing select |
| ctl_go | input | 1 | Go bit; starts a transfer when idle |
| ctl_irq_en | input | 1 | Interrupt on completion enable |
| owner_sec | input | 1 | Secondary bus owner selected |
| dma_arm | input | 1 | DMA armed for this source |
| rd_valid | output | 1 | Word ready in read buffer |
| rd_ready | input | 1 | Host pop strobe |
| rd_data | output | 32 | Read buffer |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last start had an unknown opcode |
| irq | output | 1 | Completion interrupt pulse |
| dma_req | output | 1 | Per-word DMA request pulse |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | 32 | ROM byte address |
| rom_rdata | input | 32 | ROM data, valid the cycle after `rom_en` |

## Verification
The properties assume a ROM that returns data exactly one cycle after `rom_en`. They also assume that `rd_ready` is the only way a word leaves the buffer. The bench ROM model registers `rom_rdata` on every `rom_en`, using a fixed arithmetic function of `rom_addr`. Each delivered word can therefore be predicted from the programmed start address alone. The bench holds `owner_sec` and `dma_arm` constant during each transfer, so the expected pacing delay is the same for the whole stream.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int unsigned CMD_BYTES  = 8;
  localparam int unsigned USED_BYTES = 5;
  localparam int unsigned IDX_W      = $clog2(CMD_BYTES);
  localparam int unsigned BLK_UNIT   = 256;
  localparam int unsigned MAX_CODE   = 6;
  localparam int unsigned MAX_BYTES  = BLK_UNIT << MAX_CODE;
  localparam int unsigned REM_W      = $clog2(MAX_BYTES + 1);
  localparam int unsigned WORD_W     = 32;

  localparam logic [7:0] OP_STREAM = 8'hB7;
  localparam logic [7:0] OP_IDENT  = 8'hB8;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_FETCH, S_CAPT, S_HOLD, S_BAD
  } seq_state_t;

  typedef struct packed {
    logic [7:0]        op;
    logic [WORD_W-1:0] addr;
  } cmd_view_t;

  function automatic logic [REM_W-1:0] blk_bytes(input logic [2:0] code);
    logic [REM_W-1:0] r;
    case (code)
      3'd0:    r = '0;
      3'd7:    r = REM_W'(4);
      default: r = REM_W'(BLK_UNIT) << code;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/crx_cmd_bank.sv
module crx_cmd_bank
  import crx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  output cmd_view_t        view
);
  logic [7:0] byte_q [USED_BYTES];

  for (genvar i = 0; i < USED_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))
        byte_q[i] <= wr_byte;
    end
  end

  always_comb begin
    view.op   = byte_q[0];
    view.addr = {byte_q[1], byte_q[2], byte_q[3], byte_q[4]};
  end
endmodule

// File: rtl/crx_pacer.sv
module crx_pacer #(
  parameter int unsigned FAST_CYC = 5,
  parameter int unsigned SLOW_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic slow,
  input  logic owner_sec,
  output logic expire
);
  localparam int unsigned MAX_BASE = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int unsigned CW       = $clog2(2 * MAX_BASE);

  logic [CW:0]   span;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_comb begin
    span = slow ? (CW+1)'(SLOW_CYC) : (CW+1)'(FAST_CYC);
    if (!owner_sec)
      span = span << 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CW'(span - 1'b1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0)
        run_q <= 1'b0;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run_q && (cnt_q == '0);
endmodule

// File: rtl/crx_seq.sv
module crx_seq
  import crx_pkg::*;
#(
  parameter logic [WORD_W-1:0] CHIP_ID = 32'h0000_1FC2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_view_t         view,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_size,
  input  logic              ctl_slow,
  input  logic              ctl_go,
  input  logic              ctl_irq_en,
  input  logic              dma_arm,
  input  logic              expire,
  input  logic              rd_ready,
  input  logic [WORD_W-1:0] rom_rdata,
  output logic              pace_load,
  output logic              pace_slow,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              err,
  output logic              irq,
  output logic              dma_req,
  output logic              rom_en,
  output logic [WORD_W-1:0] rom_addr
);
  seq_state_t        state_q;
  logic [WORD_W-1:0] addr_q, buf_q;
  logic [REM_W-1:0]  rem_q;
  logic              valid_q, irq_q, dma_q, err_q, irq_en_q, slow_q;
  logic              start, pop;

  assign start = ctl_we && ctl_go && (state_q == S_IDLE);
  assign pop   = (state_q == S_HOLD) && valid_q && rd_ready;

  assign pace_load = (start && view.op == OP_STREAM) || pop;
  assign pace_slow = start ? ctl_slow : slow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      buf_q    <= '0;
      rem_q    <= '0;
      valid_q  <= 1'b0;
      irq_q    <= 1'b0;
      dma_q    <= 1'b0;
      err_q    <= 1'b0;
      irq_en_q <= 1'b0;
      slow_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            irq_en_q <= ctl_irq_en;
            slow_q   <= ctl_slow;
            err_q    <= 1'b0;
            case (view.op)
              OP_STREAM: begin
                addr_q  <= view.addr;
                rem_q   <= blk_bytes(ctl_size);
                state_q <= S_WAIT;
              end
              OP_IDENT: begin
                buf_q   <= CHIP_ID;
                rem_q   <= '0;
                valid_q <= 1'b1;
                state_q <= S_HOLD;
              end
              default: begin
                err_q   <= 1'b1;
                state_q <= S_BAD;
              end
            endcase
          end
        end
        S_WAIT: begin
          if (expire) begin
            if (rem_q != '0) begin
              state_q <= S_FETCH;
            end else begin
              buf_q   <= '0;
              valid_q <= 1'b0;
              irq_q   <= irq_en_q;
              state_q <= S_IDLE;
            end
          end
        end
        S_FETCH: state_q <= S_CAPT;
        S_CAPT: begin
          buf_q   <= rom_rdata;
          valid_q <= 1'b1;
          addr_q  <= addr_q + WORD_W'(4);
          rem_q   <= rem_q - REM_W'(4);
          dma_q   <= dma_arm;
          state_q <= S_HOLD;
        end
        S_HOLD: begin
          if (pop) begin
            valid_q <= 1'b0;
            state_q <= S_WAIT;
          end
        end
        S_BAD:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = buf_q;
  assign busy     = (state_q != S_IDLE);
  assign err      = err_q;
  assign irq      = irq_q;
  assign dma_req  = dma_q;
  assign rom_en   = (state_q == S_FETCH);
  assign rom_addr = addr_q;
endmodule

// File: rtl/crx_rom_reader.sv
module crx_rom_reader
  import crx_pkg::*;
#(
  parameter logic [31:0] CHIP_ID  = 32'h0000_1FC2,
  parameter int unsigned FAST_CYC = 5,
  parameter int unsigned SLOW_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [2:0]  cmd_idx,
  input  logic [7:0]  cmd_byte,
  input  logic        ctl_we,
  input  logic [2:0]  ctl_size,
  input  logic        ctl_slow,
  input  logic        ctl_go,
  input  logic        ctl_irq_en,
  input  logic        owner_sec,
  input  logic        dma_arm,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        err,
  output logic        irq,
  output logic        dma_req,
  output logic        rom_en,
  output logic [31:0] rom_addr,
  input  logic [31:0] rom_rdata
);
  cmd_view_t view;
  logic      pace_load, pace_slow, expire;

  crx_cmd_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_we),
    .wr_idx  (cmd_idx),
    .wr_byte (cmd_byte),
    .view    (view)
  );

  crx_pacer #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pace_load),
    .slow      (pace_slow),
    .owner_sec (owner_sec),
    .expire    (expire)
  );

  crx_seq #(.CHIP_ID(CHIP_ID)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .view       (view),
    .ctl_we     (ctl_we),
    .ctl_size   (ctl_size),
    .ctl_slow   (ctl_slow),
    .ctl_go     (ctl_go),
    .ctl_irq_en (ctl_irq_en),
    .dma_arm    (dma_arm),
    .expire     (expire),
    .rd_ready   (rd_ready),
    .rom_rdata  (rom_rdata),
    .pace_load  (pace_load),
    .pace_slow  (pace_slow),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .busy       (busy),
    .err        (err),
    .irq        (irq),
    .dma_req    (dma_req),
    .rom_en     (rom_en),
    .rom_addr   (rom_addr)
  );
endmodule

// File: rtl/crx_rom_reader_chk.sv
module crx_rom_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_data,
  input logic        busy,
  input logic        err,
  input logic        irq,
  input logic        dma_req,
  input logic        rom_en,
  input logic [31:0] rom_addr
);
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r6_no_fetch_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rom_en);

  a_r6_valid_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> !rom_en);

  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |=> $stable(rom_addr));

  a_r10_dma_on_new_word: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rd_valid && !$past(rd_valid));

  a_r7_irq_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && !rd_valid && rd_data == 32'h0);

  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r9_bad_opcode_short: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |=> !busy);
endmodule

bind crx_rom_reader crx_rom_reader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .busy     (busy),
  .err      (err),
  .irq      (irq),
  .dma_req  (dma_req),
  .rom_en   (rom_en),
  .rom_addr (rom_addr)
);

// File: tb/crx_rom_reader_test.sv
module crx_rom_reader_test;
  localparam logic [31:0] ID = 32'h0000_1FC2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_idx = '0;
  logic [7:0]  cmd_byte = '0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_size = '0;
  logic        ctl_slow = 1'b0;
  logic        ctl_go = 1'b0;
  logic        ctl_irq_en = 1'b0;
  logic        owner_sec = 1'b1;
  logic        dma_arm = 1'b0;
  logic        rd_ready = 1'b0;
  logic        rd_valid, busy, err, irq, dma_req, rom_en;
  logic [31:0] rd_data, rom_addr;
  logic [31:0] rom_rdata = '0;

  int checks = 0;
  int errors = 0;
  int rom_hits = 0;

  crx_rom_reader #(.CHIP_ID(ID)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte),
    .ctl_we(ctl_we), .ctl_size(ctl_size), .ctl_slow(ctl_slow), .ctl_go(ctl_go),
    .ctl_irq_en(ctl_irq_en), .owner_sec(owner_sec), .dma_arm(dma_arm),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy), .err(err),
    .irq(irq), .dma_req(dma_req), .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return (a ^ 32'hC3A5_0F96) + {a[15:0], a[31:16]};
  endfunction

  always @(posedge clk) begin
    if (rom_en) begin
      rom_rdata <= rom_word(rom_addr);
      rom_hits  <= rom_hits + 1;
    end
  end

  function automatic int exp_bytes(input logic [2:0] code);
    if (code == 3'd0) return 0;
    if (code == 3'd7) return 4;
    return 256 << code;
  endfunction

  function automatic int exp_lat(input bit slow, input bit own);
    int b = slow ? 8 : 5;
    return own ? b : 2 * b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put_byte(input int idx, input logic [7:0] b);
    cmd_we = 1'b1; cmd_idx = 3'(idx); cmd_byte = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic load_cmd(input logic [7:0] op, input logic [31:0] a);
    put_byte(0, op);
    put_byte(1, a[31:24]);
    put_byte(2, a[23:16]);
    put_byte(3, a[15:8]);
    put_byte(4, a[7:0]);
    put_byte(5, 8'h00);
  endtask

  task automatic kick(input logic [2:0] code, input bit slow, input bit ie);
    ctl_we = 1'b1; ctl_go = 1'b1; ctl_size = code; ctl_slow = slow; ctl_irq_en = ie;
    @(negedge clk);
    ctl_we = 1'b0; ctl_go = 1'b0;
  endtask

  task automatic pop();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic wait_valid(inout int k);
    while (!rd_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finish_close(input int lat, input bit ie, input string tag);
    int k = 0;
    while (busy && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(k == lat, "R7", {tag, " close delay"}, 32'(k), 32'(lat));
    check(irq == ie, "R7", {tag, " irq on close"}, 32'(irq), 32'(ie));
    check(rd_data == 32'h0, "R7", {tag, " buffer cleared"}, rd_data, 32'h0);
  endtask

  task automatic run_stream(input logic [31:0] a0, input logic [2:0] code, input bit slow,
                            input bit own, input bit ie, input bit arm, input string tag);
    int words = exp_bytes(code) / 4;
    int lat = exp_lat(slow, own);
    int bad_lat = 0, bad_dat = 0, bad_dma = 0;
    int hits0;
    logic [31:0] got_bad = '0, exp_bad = '0;
    load_cmd(8'hB7, a0);
    owner_sec = own; dma_arm = arm;
    hits0 = rom_hits;
    kick(code, slow, ie);
    for (int w = 0; w < words; w++) begin
      int k = 0;
      wait_valid(k);
      if (k != lat + 2) bad_lat++;
      if (rd_data != rom_word(a0 + 32'(4 * w))) begin
        if (bad_dat == 0) begin got_bad = rd_data; exp_bad = rom_word(a0 + 32'(4 * w)); end
        bad_dat++;
      end
      if (dma_req != arm) bad_dma++;
      pop();
    end
    finish_close(lat, ie, tag);
    check(bad_lat == 0, "R5", {tag, " word latency misses"}, 32'(bad_lat), 0);
    check(bad_dat == 0, "R3", {tag, " word data"}, got_bad, exp_bad);
    check(bad_dma == 0, "R10", {tag, " dma pulses"}, 32'(bad_dma), 0);
    check(rom_hits - hits0 == words, "R4", {tag, " word count"}, 32'(rom_hits - hits0), 32'(words));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, rd_valid, irq, dma_req, err, rom_en} == 6'b0, "R1", "reset outputs",
          32'({busy, rd_valid, irq, dma_req, err, rom_en}), 0);

    // R3 R4 R5 R10 sweep over every size code
    for (int c = 0; c < 8; c++)
      run_stream(32'h0010_0000 * 32'(c) + 32'h40, 3'(c), 1'b0, 1'b1, !c[1], c[0], "sweep");

    // R5 pacing matrix
    for (int s = 0; s < 2; s++)
      for (int o = 0; o < 2; o++)
        run_stream(32'hABCD_0100 + 32'(16 * (2 * s + o)), 3'd7, s[0], o[0], 1'b1, 1'b1, "pace");

    // R6 back-pressure: word held while not popped
    begin
      int k = 0;
      int moved = 0;
      logic [31:0] held;
      load_cmd(8'hB7, 32'h0000_2000);
      owner_sec = 1'b1; dma_arm = 1'b0;
      kick(3'd7, 1'b0, 1'b0);
      wait_valid(k);
      held = rd_data;
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        if (!rd_valid || rd_data != held || rom_en) moved++;
      end
      check(moved == 0, "R6", "hold without pop", 32'(moved), 0);
      check(held == rom_word(32'h0000_2000), "R6", "held word", held, rom_word(32'h0000_2000));
      pop();
      finish_close(5, 1'b0, "hold");
    end

    // R2 go ignored while busy; staging update used only at next start
    begin
      int k;
      load_cmd(8'hB7, 32'h0055_AA00);
      owner_sec = 1'b1; dma_arm = 1'b1;
      kick(3'd7, 1'b1, 1'b1);
      put_byte(0, 8'h3C);
      kick(3'd0, 1'b0, 1'b0);
      put_byte(0, 8'hB8);
      k = 3;
      wait_valid(k);
      check(k == 10, "R2", "latency with ignored go", 32'(k), 32'd10);
      check(rd_data == rom_word(32'h0055_AA00), "R2", "data with ignored go",
            rd_data, rom_word(32'h0055_AA00));
      check(err == 1'b0, "R2", "err untouched", 32'(err), 0);
      pop();
      finish_close(8, 1'b1, "ignored go");
    end

    // R8 identity opcode (staged during previous transfer)
    kick(3'd3, 1'b1, 1'b1);
    check(rd_valid && busy, "R8", "id word ready", 32'({rd_valid, busy}), 32'h3);
    check(rd_data == ID, "R8", "id value", rd_data, ID);
    pop();
    finish_close(8, 1'b1, "id");

    // R9 unknown opcode
    put_byte(0, 8'h3C);
    kick(3'd2, 1'b0, 1'b1);
    check(busy && err && !rd_valid, "R9", "bad opcode first cycle",
          32'({busy, err, rd_valid}), 32'h6);
    @(negedge clk);
    check(!busy && err && !irq && !rd_valid, "R9", "bad opcode closed",
          32'({busy, err, irq, rd_valid}), 32'h2);
    check(rd_data == 32'h0, "R9", "buffer unchanged", rd_data, 32'h0);
    load_cmd(8'hB7, 32'h0000_0800);
    kick(3'd7, 1'b0, 1'b0);
    check(err == 1'b0, "R9", "err cleared by next start", 32'(err), 0);
    begin
      int k = 0;
      wait_valid(k);
      check(rd_data == rom_word(32'h0000_0800), "R11", "address after recovery",
            rd_data, rom_word(32'h0000_0800));
      pop();
      finish_close(5, 1'b0, "recover");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule